// File: doc/BRIEF.md
# Four-Port Parity-Protected Memory Bank

This block is one storage bank of a larger banked memory. Up to four independent requesters, such as a processor, a block-transfer channel engine or an external mass-storage device, share it. Each requester presents a 16-bit address, a read or write selection and a transfer size. The upper part of the address names a bank and the lower part names a word inside it. A request counts only when the bank field equals the number this bank was built with.

Each stored word is 36 bits wide. It holds 32 data bits and, for each 16-bit half, one marker bit and one parity bit. On a write the bank generates odd parity for every half it writes. On a read it checks the parity of the halves that were asked for and flags any mismatch toward the interrupt logic. When several ports request in the same cycle, a fixed-priority arbiter serves them one per cycle, so no request is dropped. The storage is held in synchronous RAM lanes, one lane per half-word, so that half-word and marker-only writes need no read-modify-write.

Top module: `mpbank_ctrl`

## Requirements
- R1: A word-size transfer (size code 0) writes all 32 data bits and both marker bits (`wmark[1]` belongs to bits 31:16, `wmark[0]` to bits 15:0). A later read returns the same data on `rd_data` and the same markers on `rd_mark`.
- R2: On each write the bank stores odd parity for every half written: the half's ones plus its parity bit give an odd count. A read of data written with `par_inject` low returns `par_err` low.
- R3: `par_err` is high together with `rd_valid` when a checked half fails odd parity. Size 0 checks both halves, size 1 checks the upper half, size 2 checks the lower half and size 3 checks none. While `par_inject` is high, writes store inverted parity for the upper half only.
- R4: Among ports whose requests are eligible, the lowest-numbered port wins. At most one `p_ack` bit is high in any cycle, and an eligible port 0 request that is not being acknowledged is acknowledged in the next cycle.
- R5: `p_ack` is a one-cycle pulse that appears in the cycle after the request is sampled. A port is never granted in the cycle its acknowledge is high. A request that is held until acknowledged is always served, so simultaneous requests from all four ports are acknowledged in consecutive cycles and none is lost.
- R6: An upper-half write (size 1) or a lower-half write (size 2) changes only that half's data, marker and parity. The other half reads back unchanged.
- R7: A marker-only write (size 3) changes only the two marker bits. The data and parity of the word read back unchanged.
- R8: The top `ADDR_W-WORD_AW` address bits form the bank field and the low `WORD_AW` bits form the word index. `WORD_AW` is 13 for an 8192-word bank and 14 for a 16384-word bank; the default build uses 10. `bank_hit[i]` is high only when port i's bank field equals `BANK_NUM`, which defaults to 5. A request that does not match is never acknowledged and leaves the storage unchanged.
- R9: A read produces `rd_valid` for one cycle, one cycle after its `p_ack`. In that cycle `rd_port` carries the requesting port's number and `rd_data` carries the full stored word.
- R10: While reset is held, and in the first cycle after it, `p_ack`, `rd_valid` and `par_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| par_inject | input | 1 | Store inverted upper-half parity on writes (fault test) |
| p_req | input | NP | Request per port, held until acknowledged |
| p_we | input | NP | Per port: 1 write, 0 read |
| p_size | input | 2*NP | Per port size code: 0 word, 1 upper half, 2 lower half, 3 markers |
| p_addr | input | ADDR_W*NP | Per port 16-bit address |
| p_wdata | input | 32*NP | Per port write data |
| p_wmark | input | 2*NP | Per port marker bits {upper, lower} |
| bank_hit | output | NP | Port's bank field matches this bank |
| p_ack | output | NP | One-cycle grant acknowledge per port |
| rd_valid | output | 1 | Read data valid |
| rd_port | output | IDX_W | Port that issued the returned read |
| rd_data | output | 32 | Full stored data word |
| rd_mark | output | 2 | Stored marker bits {upper, lower} |
| par_err | output | 1 | Parity failure on the checked halves |

## Verification
The assertions assume that every requester keeps its request and its request fields stable until it sees its acknowledge. They also assume that a port drops the request in its acknowledge cycle and that a write's fields never change while the request is pending. The bench drives all inputs on the falling edge and lowers each request in the same half cycle in which it sees the acknowledge. It reads only words it has already written, so the parity and marker checks never see uninitialised storage.

// File: rtl/mpbank_pkg.sv
package mpbank_pkg;

  typedef enum logic [1:0] {
    SZ_WORD  = 2'd0,
    SZ_UPPER = 2'd1,
    SZ_LOWER = 2'd2,
    SZ_MARK  = 2'd3
  } xfer_size_e;

  // True when a transfer of size s moves the data of the given half.
  function automatic logic half_data_sel(input xfer_size_e s, input logic upper);
    return (s == SZ_WORD) || (s == (upper ? SZ_UPPER : SZ_LOWER));
  endfunction

  // True when a transfer of size s moves the marker bit of the given half.
  function automatic logic half_mark_sel(input xfer_size_e s, input logic upper);
    return half_data_sel(s, upper) || (s == SZ_MARK);
  endfunction

endpackage

// File: rtl/mpbank_arb.sv
module mpbank_arb #(
  parameter int NP    = 4,
  parameter int IDX_W = 2
) (
  input  logic [NP-1:0]    cand,
  output logic             gnt_vld,
  output logic [IDX_W-1:0] gnt_idx
);

  // Fixed priority: the lowest index wins.
  always_comb begin
    gnt_vld = |cand;
    gnt_idx = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (cand[i]) gnt_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/mpbank_sel.sv
module mpbank_sel
  import mpbank_pkg::*;
#(
  parameter int NP       = 4,
  parameter int IDX_W    = 2,
  parameter int ADDR_W   = 16,
  parameter int WORD_AW  = 10,
  parameter int DATA_W   = 32,
  parameter int BANK_NUM = 5
) (
  input  logic [ADDR_W*NP-1:0] p_addr,
  input  logic [NP-1:0]        p_we,
  input  logic [2*NP-1:0]      p_size,
  input  logic [DATA_W*NP-1:0] p_wdata,
  input  logic [2*NP-1:0]      p_wmark,
  input  logic [IDX_W-1:0]     idx,
  output logic [NP-1:0]        hit,
  output logic                 sel_we,
  output xfer_size_e           sel_size,
  output logic [WORD_AW-1:0]   sel_word,
  output logic [DATA_W-1:0]    sel_wdata,
  output logic [1:0]           sel_wmark
);

  localparam int BSEL_W = ADDR_W - WORD_AW;

  // Bank-field decode, one comparator per port.
  for (genvar i = 0; i < NP; i++) begin : g_hit
    assign hit[i] = (p_addr[i*ADDR_W + WORD_AW +: BSEL_W] == BSEL_W'(BANK_NUM));
  end

  // Fields of the granted port.
  always_comb begin
    sel_we    = p_we[idx];
    sel_size  = xfer_size_e'(p_size[idx*2 +: 2]);
    sel_word  = p_addr[idx*ADDR_W +: WORD_AW];
    sel_wdata = p_wdata[idx*DATA_W +: DATA_W];
    sel_wmark = p_wmark[idx*2 +: 2];
  end

endmodule

// File: rtl/mpbank_lane.sv
module mpbank_lane #(
  parameter int WORD_AW = 10,
  parameter int HALF_W  = 16
) (
  input  logic               clk,
  input  logic [WORD_AW-1:0] word,
  input  logic               d_we,
  input  logic               m_we,
  input  logic               rd_en,
  input  logic [HALF_W-1:0]  wdata,
  input  logic               wmark,
  input  logic               flip_par,
  output logic [HALF_W-1:0]  q_data,
  output logic               q_par,
  output logic               q_mark
);

  localparam int DEPTH = 1 << WORD_AW;

  logic [HALF_W:0] dmem [DEPTH];
  logic            mmem [DEPTH];
  logic            gen_par;

  // Odd parity: data ones plus parity bit give an odd count.
  assign gen_par = ~(^wdata) ^ flip_par;

  always_ff @(posedge clk) begin
    if (d_we) dmem[word] <= {gen_par, wdata};
    if (rd_en) {q_par, q_data} <= dmem[word];
  end

  always_ff @(posedge clk) begin
    if (m_we) mmem[word] <= wmark;
    if (rd_en) q_mark <= mmem[word];
  end

endmodule

// File: rtl/mpbank_ctrl.sv
module mpbank_ctrl
  import mpbank_pkg::*;
#(
  parameter int NP       = 4,
  parameter int ADDR_W   = 16,
  parameter int WORD_AW  = 10,
  parameter int DATA_W   = 32,
  parameter int BANK_NUM = 5,
  localparam int IDX_W   = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 par_inject,
  input  logic [NP-1:0]        p_req,
  input  logic [NP-1:0]        p_we,
  input  logic [2*NP-1:0]      p_size,
  input  logic [ADDR_W*NP-1:0] p_addr,
  input  logic [DATA_W*NP-1:0] p_wdata,
  input  logic [2*NP-1:0]      p_wmark,
  output logic [NP-1:0]        bank_hit,
  output logic [NP-1:0]        p_ack,
  output logic                 rd_valid,
  output logic [IDX_W-1:0]     rd_port,
  output logic [DATA_W-1:0]    rd_data,
  output logic [1:0]           rd_mark,
  output logic                 par_err
);

  localparam int HALF_W = DATA_W / 2;

  logic [NP-1:0]      ack_q;
  logic [NP-1:0]      cand;
  logic               gnt_vld;
  logic [IDX_W-1:0]   gnt_idx;
  logic               sel_we;
  xfer_size_e         sel_size;
  logic [WORD_AW-1:0] sel_word;
  logic [DATA_W-1:0]  sel_wdata;
  logic [1:0]         sel_wmark;

  logic               s1_vld;
  logic [IDX_W-1:0]   s1_port;
  xfer_size_e         s1_size;

  logic [HALF_W-1:0]  q_data [2];
  logic [1:0]         q_par;
  logic [1:0]         q_mark;
  logic [1:0]         half_bad;

  // A port is not a candidate in the cycle its acknowledge is high.
  assign cand  = p_req & bank_hit & ~ack_q;
  assign p_ack = ack_q;

  mpbank_sel #(
    .NP(NP), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .WORD_AW(WORD_AW),
    .DATA_W(DATA_W), .BANK_NUM(BANK_NUM)
  ) sel_i (
    .p_addr(p_addr), .p_we(p_we), .p_size(p_size), .p_wdata(p_wdata),
    .p_wmark(p_wmark), .idx(gnt_idx), .hit(bank_hit), .sel_we(sel_we),
    .sel_size(sel_size), .sel_word(sel_word), .sel_wdata(sel_wdata),
    .sel_wmark(sel_wmark)
  );

  mpbank_arb #(.NP(NP), .IDX_W(IDX_W)) arb_i (
    .cand(cand), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
  );

  // One RAM lane per half-word: index 1 is bits 31:16, index 0 is bits 15:0.
  for (genvar h = 0; h < 2; h++) begin : g_lane
    logic d_we_h, m_we_h, flip_h;
    assign d_we_h = gnt_vld && sel_we && half_data_sel(sel_size, h == 1);
    assign m_we_h = gnt_vld && sel_we && half_mark_sel(sel_size, h == 1);
    assign flip_h = (h == 1) ? par_inject : 1'b0;

    mpbank_lane #(.WORD_AW(WORD_AW), .HALF_W(HALF_W)) lane_i (
      .clk(clk), .word(sel_word), .d_we(d_we_h), .m_we(m_we_h),
      .rd_en(gnt_vld && !sel_we), .wdata(sel_wdata[h*HALF_W +: HALF_W]),
      .wmark(sel_wmark[h]), .flip_par(flip_h), .q_data(q_data[h]),
      .q_par(q_par[h]), .q_mark(q_mark[h])
    );

    assign half_bad[h] = ~(^{q_par[h], q_data[h]});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q    <= '0;
      s1_vld   <= 1'b0;
      s1_port  <= '0;
      s1_size  <= SZ_WORD;
      rd_valid <= 1'b0;
      rd_port  <= '0;
      rd_data  <= '0;
      rd_mark  <= '0;
      par_err  <= 1'b0;
    end else begin
      ack_q    <= gnt_vld ? (NP'(1) << gnt_idx) : '0;
      s1_vld   <= gnt_vld && !sel_we;
      s1_port  <= gnt_idx;
      s1_size  <= sel_size;
      rd_valid <= s1_vld;
      rd_port  <= s1_port;
      rd_data  <= {q_data[1], q_data[0]};
      rd_mark  <= q_mark;
      par_err  <= s1_vld &&
                  ((half_data_sel(s1_size, 1'b1) && half_bad[1]) ||
                   (half_data_sel(s1_size, 1'b0) && half_bad[0]));
    end
  end

  // ---------------- assertions ----------------
  a_r4_ack_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(p_ack));

  a_r4_port0_next: assert property (@(posedge clk) disable iff (rst)
    (p_req[0] && bank_hit[0] && !p_ack[0]) |=> p_ack[0]);

  a_r9_valid_after_ack: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(|p_ack));

  a_r3_err_with_valid: assert property (@(posedge clk) disable iff (rst)
    par_err |-> rd_valid);

  for (genvar i = 0; i < NP; i++) begin : g_port_chk
    a_r5_ack_pulse: assert property (@(posedge clk) disable iff (rst)
      p_ack[i] |=> !p_ack[i]);

    a_r8_ack_had_hit: assert property (@(posedge clk) disable iff (rst)
      $rose(p_ack[i]) |-> $past(p_req[i] && bank_hit[i]));
  end

endmodule

// File: tb/mpbank_ctrl_tb_top.sv
module mpbank_ctrl_tb_top;

  localparam int NP = 4;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [5:0] MYBANK = 6'd5;
  localparam logic [5:0] OTHER  = 6'd6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic par_inject = 1'b0;
  logic [NP-1:0] p_req = '0;
  logic [NP-1:0] p_we = '0;
  logic [2*NP-1:0] p_size = '0;
  logic [AW*NP-1:0] p_addr = '0;
  logic [DW*NP-1:0] p_wdata = '0;
  logic [2*NP-1:0] p_wmark = '0;
  logic [NP-1:0] bank_hit;
  logic [NP-1:0] p_ack;
  logic rd_valid;
  logic [1:0] rd_port;
  logic [DW-1:0] rd_data;
  logic [1:0] rd_mark;
  logic par_err;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] r_data;
  logic [1:0]  r_mark;
  logic        r_err;

  always #4 clk = ~clk;

  mpbank_ctrl dut_i (
    .clk(clk), .rst(rst), .par_inject(par_inject), .p_req(p_req), .p_we(p_we),
    .p_size(p_size), .p_addr(p_addr), .p_wdata(p_wdata), .p_wmark(p_wmark),
    .bank_hit(bank_hit), .p_ack(p_ack), .rd_valid(rd_valid), .rd_port(rd_port),
    .rd_data(rd_data), .rd_mark(rd_mark), .par_err(par_err)
  );

  function automatic logic [15:0] mk(input logic [5:0] bank, input int word);
    return {bank, 10'(word)};
  endfunction

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic set_port(input int pt, input logic we, input logic [1:0] sz,
                          input logic [15:0] addr, input logic [31:0] wd,
                          input logic [1:0] wm);
    p_we[pt] = we;
    p_size[pt*2 +: 2] = sz;
    p_addr[pt*AW +: AW] = addr;
    p_wdata[pt*DW +: DW] = wd;
    p_wmark[pt*2 +: 2] = wm;
    p_req[pt] = 1'b1;
  endtask

  // Single access; read results land in r_data, r_mark and r_err.
  task automatic access(input string rq, input int pt, input logic we,
                        input logic [1:0] sz, input logic [15:0] addr,
                        input logic [31:0] wd, input logic [1:0] wm);
    bit got = 0;
    @(negedge clk);
    set_port(pt, we, sz, addr, wd, wm);
    for (int k = 0; k < 16 && !got; k++) begin
      @(negedge clk);
      if (p_ack[pt]) got = 1;
    end
    p_req[pt] = 1'b0;
    chk(rq, "acknowledge seen", 64'(got), 64'd1);
    if (!we && got) begin
      @(negedge clk);
      chk(rq, "rd_valid one cycle after ack", 64'(rd_valid), 64'd1);
      chk(rq, "rd_port", 64'(rd_port), 64'(pt));
      r_data = rd_data;
      r_mark = rd_mark;
      r_err  = par_err;
    end
  endtask

  task automatic t_reset;
    chk("R10", "p_ack in reset", 64'(p_ack), 64'd0);
    chk("R10", "rd_valid in reset", 64'(rd_valid), 64'd0);
    chk("R10", "par_err in reset", 64'(par_err), 64'd0);
  endtask

  task automatic t_full_word;
    access("R1", 1, 1'b1, 2'd0, mk(MYBANK, 7), 32'hDEAD_BEEF, 2'b10);
    access("R1", 2, 1'b0, 2'd0, mk(MYBANK, 7), 32'h0, 2'b00);
    chk("R1", "full word data", 64'(r_data), 64'hDEAD_BEEF);
    chk("R1", "full word markers", 64'(r_mark), 64'h2);
    chk("R2", "clean parity", 64'(r_err), 64'd0);
    access("R9", 3, 1'b1, 2'd0, mk(MYBANK, 8), 32'h0000_0000, 2'b01);
    access("R9", 3, 1'b0, 2'd0, mk(MYBANK, 8), 32'h0, 2'b00);
    chk("R9", "all-zero data", 64'(r_data), 64'h0);
    chk("R2", "zero data parity", 64'(r_err), 64'd0);
    chk("R1", "zero word markers", 64'(r_mark), 64'h1);
  endtask

  task automatic t_half_write;
    access("R6", 0, 1'b1, 2'd0, mk(MYBANK, 20), 32'h1234_5678, 2'b11);
    access("R6", 0, 1'b1, 2'd1, mk(MYBANK, 20), 32'hABCD_FFFF, 2'b00);
    access("R6", 1, 1'b0, 2'd0, mk(MYBANK, 20), 32'h0, 2'b00);
    chk("R6", "upper write data", 64'(r_data), 64'hABCD_5678);
    chk("R6", "upper write markers", 64'(r_mark), 64'h1);
    chk("R6", "upper write parity", 64'(r_err), 64'd0);
    access("R6", 2, 1'b1, 2'd2, mk(MYBANK, 20), 32'hFFFF_0F0F, 2'b10);
    access("R6", 2, 1'b0, 2'd0, mk(MYBANK, 20), 32'h0, 2'b00);
    chk("R6", "lower write data", 64'(r_data), 64'hABCD_0F0F);
    chk("R6", "lower write markers", 64'(r_mark), 64'h0);
  endtask

  task automatic t_mark_only;
    access("R7", 3, 1'b1, 2'd0, mk(MYBANK, 30), 32'h5555_AAAA, 2'b00);
    access("R7", 3, 1'b1, 2'd3, mk(MYBANK, 30), 32'hFFFF_FFFF, 2'b11);
    access("R7", 0, 1'b0, 2'd0, mk(MYBANK, 30), 32'h0, 2'b00);
    chk("R7", "data kept", 64'(r_data), 64'h5555_AAAA);
    chk("R7", "markers set", 64'(r_mark), 64'h3);
    chk("R7", "parity kept", 64'(r_err), 64'd0);
  endtask

  task automatic t_conflict;
    int order [4];
    int n = 0;
    int multi = 0;
    @(negedge clk);
    for (int p = 0; p < NP; p++)
      set_port(p, 1'b1, 2'd0, mk(MYBANK, 100 + p), 32'hC0DE_0000 + 32'(p), 2'(p));
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if ($countones(p_ack) > 1) multi++;
      for (int p = 0; p < NP; p++) begin
        if (p_ack[p]) begin
          if (n < 4) order[n] = p;
          n++;
          p_req[p] = 1'b0;
        end
      end
    end
    chk("R4", "single ack per cycle", 64'(multi), 64'd0);
    chk("R5", "all four acknowledged", 64'(n), 64'd4);
    for (int k = 0; k < 4; k++)
      chk("R4", "priority order", 64'(order[k]), 64'(k));
    for (int p = 0; p < NP; p++) begin
      access("R5", 1, 1'b0, 2'd0, mk(MYBANK, 100 + p), 32'h0, 2'b00);
      chk("R5", "write not lost", 64'(r_data), 64'(32'hC0DE_0000 + 32'(p)));
    end
  endtask

  task automatic t_pulse;
    int pat = 0;
    @(negedge clk);
    set_port(3, 1'b0, 2'd0, mk(MYBANK, 7), 32'h0, 2'b00);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      pat = (pat << 1) | int'(p_ack[3]);
    end
    p_req[3] = 1'b0;
    // held request: ack, gap, ack again
    chk("R5", "ack pulse pattern", 64'(pat), 64'b101);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_miss;
    int acks = 0;
    access("R8", 0, 1'b1, 2'd0, mk(MYBANK, 50), 32'h0BAD_F00D, 2'b01);
    @(negedge clk);
    set_port(1, 1'b1, 2'd0, mk(OTHER, 50), 32'h1111_2222, 2'b10);
    set_port(2, 1'b0, 2'd0, mk(MYBANK, 50), 32'h0, 2'b00);
    p_req[2] = 1'b0;
    #1;
    chk("R8", "bank_hit other bank", 64'(bank_hit[1]), 64'd0);
    chk("R8", "bank_hit own bank", 64'(bank_hit[2]), 64'd1);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (p_ack[1]) acks++;
    end
    p_req[1] = 1'b0;
    chk("R8", "no ack on mismatch", 64'(acks), 64'd0);
    access("R8", 2, 1'b0, 2'd0, mk(MYBANK, 50), 32'h0, 2'b00);
    chk("R8", "storage unchanged", 64'(r_data), 64'h0BAD_F00D);
    chk("R8", "markers unchanged", 64'(r_mark), 64'h1);
  endtask

  task automatic t_parity;
    @(negedge clk) par_inject = 1'b1;
    access("R3", 0, 1'b1, 2'd0, mk(MYBANK, 60), 32'h0F00_00F0, 2'b00);
    @(negedge clk) par_inject = 1'b0;
    access("R3", 0, 1'b0, 2'd0, mk(MYBANK, 60), 32'h0, 2'b00);
    chk("R3", "full read flags bad upper", 64'(r_err), 64'd1);
    access("R3", 0, 1'b0, 2'd2, mk(MYBANK, 60), 32'h0, 2'b00);
    chk("R3", "lower read unaffected", 64'(r_err), 64'd0);
    access("R3", 0, 1'b0, 2'd1, mk(MYBANK, 60), 32'h0, 2'b00);
    chk("R3", "upper read flags", 64'(r_err), 64'd1);
    access("R3", 0, 1'b0, 2'd3, mk(MYBANK, 60), 32'h0, 2'b00);
    chk("R3", "marker read unchecked", 64'(r_err), 64'd0);
    access("R2", 1, 1'b1, 2'd1, mk(MYBANK, 60), 32'h0F00_0000, 2'b00);
    access("R2", 1, 1'b0, 2'd0, mk(MYBANK, 60), 32'h0, 2'b00);
    chk("R2", "rewrite restores parity", 64'(r_err), 64'd0);
  endtask

  initial begin
    #100000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_word();
    t_half_write();
    t_mark_only();
    t_conflict();
    t_pulse();
    t_miss();
    t_parity();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule